// File: doc/BRIEF.md
# Write-Protect Unlock Sequencer

This block stands in front of the write path of a byte-wide parallel non-volatile memory. Each completed write cycle presents its latched 15-bit address and 8-bit data together with a one-cycle strobe. The block watches these cycles for a three-cycle command prefix and decides, one cycle after each strobe, whether that cycle may go on into the array. It also holds a persistent flag that says whether software write protection is enabled.

The prefix is 0xAA at 0x5555, then 0x55 at 0x2AAA, then a key byte at 0x5555. With the arm key (0xA0), the next write is a real data write. That write is always permitted, and it sets the protection flag. A prefix with no data write after it leaves the flag unchanged. While protection is on, a write is permitted only if a complete prefix comes right before it. With the disable key (a parameter, 0x20 by default) in the third cycle, the flag is cleared instead. A partial prefix is dropped if the next strobe does not arrive within a byte-load window of `WINDOW` cycles. The flag has its own power-on reset and is not touched by the sequencer reset.

The state machine has four states. `ST_IDLE` is the rest state. `ST_GOT1` means the first code byte has been seen. `ST_GOT2` means the second has been seen. `ST_ARMED` means the prefix is complete and the next write is data. The transitions are:
- advance: `ST_IDLE` to `ST_GOT1` to `ST_GOT2` to `ST_ARMED`, each on the matching code cycle.
- commit: `ST_ARMED` to `ST_IDLE` on any write.
- unlock: `ST_GOT2` to `ST_IDLE` on the disable key.
- break: any partial state to `ST_IDLE` on a write that does not match the next code cycle.
- expire: any partial state to `ST_IDLE` when the window runs out.

Top module: `wp_unlock_seq`

## Requirements
- R1: While `rst_n` is low, the state is `ST_IDLE` and `wr_ok` is 0. While `por_n` is low, `prot_on` is 0.
- R2: With protection off, a strobed write that is not a code cycle gives `wr_ok`=1 in the cycle after the strobe. Without a strobe, `wr_ok` is 0.
- R3: A write that matches the next expected prefix cycle is never permitted. The prefix cycles are (0x5555, 0xAA), then (0x2AAA, 0x55), then (0x5555, 0xA0 or the disable key).
- R4: After (0x5555, 0xA0) completes the prefix, the next write is permitted whatever its address and data, and `prot_on` is 1 from the cycle after that write.
- R5: A completed prefix with no data write after it leaves `prot_on` unchanged.
- R6: While `prot_on` is 1, a write that does not follow a complete prefix is discarded (`wr_ok`=0).
- R7: While `prot_on` is 1, a write that follows a complete prefix is permitted and `prot_on` stays 1.
- R8: A write that breaks a started prefix is discarded, and the sequencer returns to `ST_IDLE`. The next write is then judged from idle.
- R9: Each strobe of a partial prefix must come at most `WINDOW` clock cycles after the one before it. If the gap is larger, the partial prefix is dropped, and the late write is judged from idle.
- R10: (0x5555, 0xAA), (0x2AAA, 0x55), (0x5555, `DIS_KEY`) clears `prot_on` from the cycle after the third write. None of the three is permitted.
- R11: Pulsing `rst_n` alone leaves `prot_on` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the sequencer state and of `wr_ok` |
| por_n | input | 1 | Active-low power-on reset of the protection flag |
| wr_stb | input | 1 | One-cycle strobe for a completed write cycle |
| wr_addr | input | 15 | Latched address of the write cycle |
| wr_data | input | 8 | Latched data of the write cycle |
| wr_ok | output | 1 | Registered permit for the write strobed in the previous cycle |
| prot_on | output | 1 | Persistent write-protection flag |

## Verification
The assertions assume two things about the inputs: `wr_stb` is a single-cycle pulse per write, and address and data are valid whenever it is high. The bench drives each write as one strobed cycle at the falling edge, so both assumptions always hold. The random stimulus is drawn mostly from the three prefix pairs and the disable pair, so full and broken prefixes appear often. The gaps between strobes are drawn around `WINDOW`, so both sides of the timeout boundary are covered.

// File: rtl/wp_unlock_pkg.sv
package wp_unlock_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GOT1  = 2'd1,
        ST_GOT2  = 2'd2,
        ST_ARMED = 2'd3
    } seq_state_t;

    localparam logic [14:0] CODE_ADDR_A = 15'h5555;
    localparam logic [14:0] CODE_ADDR_B = 15'h2AAA;
    localparam logic [7:0]  CODE_BYTE_1 = 8'hAA;
    localparam logic [7:0]  CODE_BYTE_2 = 8'h55;
    localparam logic [7:0]  ARM_KEY     = 8'hA0;
endpackage

// File: rtl/wp_code_match.sv
module wp_code_match
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter logic [7:0] DIS_KEY = 8'h20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] data,
    output logic              is_first,
    output logic              is_second,
    output logic              is_arm,
    output logic              is_dis
);
    localparam int CMP_W = 15;

    logic [CMP_W-1:0] a_low;
    logic             at_a;

    generate
        if (ADDR_W > CMP_W) begin : g_trim
            assign a_low = addr[CMP_W-1:0];
        end else begin : g_pad
            assign a_low = CMP_W'(addr);
        end
    endgenerate

    assign at_a      = (a_low == CODE_ADDR_A);
    assign is_first  = at_a && (data[7:0] == CODE_BYTE_1);
    assign is_second = (a_low == CODE_ADDR_B) && (data[7:0] == CODE_BYTE_2);
    assign is_arm    = at_a && (data[7:0] == ARM_KEY);
    assign is_dis    = at_a && (data[7:0] == DIS_KEY);
endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
    parameter int WINDOW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic stb,
    output logic expire
);
    localparam int CNT_W = (WINDOW > 2) ? $clog2(WINDOW) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW - 1);

    logic [CNT_W-1:0] cnt;

    assign expire = active && !stb && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active || stb || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // R9: the idle-cycle count never passes the last cycle of the window
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);
    // R9: the count starts again after every strobe
    a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> cnt == '0);
endmodule

// File: rtl/wp_unlock_seq.sv
module wp_unlock_seq
    import wp_unlock_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8,
    parameter int WINDOW = 16,
    parameter logic [7:0] DIS_KEY = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_stb,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_ok,
    output logic              prot_on
);
    seq_state_t state, nxt;
    logic is_first, is_second, is_arm, is_dis;
    logic expire;
    logic permit_n, set_prot, clr_prot;

    wp_code_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIS_KEY(DIS_KEY)) u_match (
        .addr      (wr_addr),
        .data      (wr_data),
        .is_first  (is_first),
        .is_second (is_second),
        .is_arm    (is_arm),
        .is_dis    (is_dis)
    );

    wp_load_window #(.WINDOW(WINDOW)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state != ST_IDLE),
        .stb    (wr_stb),
        .expire (expire)
    );

    always_comb begin
        nxt      = state;
        permit_n = 1'b0;
        set_prot = 1'b0;
        clr_prot = 1'b0;
        if (expire) begin
            nxt = ST_IDLE;
        end else if (wr_stb) begin
            unique case (state)
                ST_IDLE: begin
                    if (is_first) nxt = ST_GOT1;
                    else permit_n = !prot_on;
                end
                ST_GOT1: begin
                    nxt = is_second ? ST_GOT2 : ST_IDLE;
                end
                ST_GOT2: begin
                    if (is_arm) begin
                        nxt = ST_ARMED;
                    end else begin
                        nxt      = ST_IDLE;
                        clr_prot = is_dis;
                    end
                end
                ST_ARMED: begin
                    nxt      = ST_IDLE;
                    permit_n = 1'b1;
                    set_prot = 1'b1;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_ok <= 1'b0;
        else        wr_ok <= permit_n;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)        prot_on <= 1'b0;
        else if (set_prot) prot_on <= 1'b1;
        else if (clr_prot) prot_on <= 1'b0;
    end

    // R2: a permit always belongs to a strobed write
    a_r2_permit_from_stb: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        wr_ok |-> $past(wr_stb));
    // R4: protection turns on only through a write taken in the armed state
    a_r4_enable_path: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $rose(prot_on) |-> $past(state == ST_ARMED && wr_stb));
    // R10: protection turns off only on the third prefix cycle
    a_r10_disable_path: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        $fell(prot_on) |-> $past(state == ST_GOT2 && wr_stb));
    // R6: under protection a permit needs a completed prefix
    a_r6_guarded_write: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_ok && $past(prot_on)) |-> $past(state == ST_ARMED));
    // R3: code cycles matching the next step are never permitted
    a_r3_code_blocked: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_stb && state == ST_GOT1 && is_second) |=> !wr_ok);
endmodule

// File: tb/sim_wp_unlock_seq.sv
module sim_wp_unlock_seq;
    localparam int W = 16;
    localparam logic [7:0] DK = 8'h20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_n = 1'b0;
    logic wr_stb = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic wr_ok, prot_on;

    int n_chk = 0;
    int n_bad = 0;
    int m_state = 0;
    bit m_prot = 1'b0;
    int since = 1000;

    always #10 clk = ~clk;

    wp_unlock_seq #(.WINDOW(W), .DIS_KEY(DK)) u0 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_ok(wr_ok), .prot_on(prot_on)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic bit model_step(input logic [14:0] a, input logic [7:0] d, input int gap);
        bit p = 1'b0;
        if (m_state != 0 && gap > W) m_state = 0;
        case (m_state)
            0: if (a == 15'h5555 && d == 8'hAA) m_state = 1; else p = !m_prot;
            1: m_state = (a == 15'h2AAA && d == 8'h55) ? 2 : 0;
            2: begin
                if (a == 15'h5555 && d == 8'hA0) m_state = 3;
                else begin
                    if (a == 15'h5555 && d == DK) m_prot = 1'b0;
                    m_state = 0;
                end
            end
            default: begin p = 1'b1; m_prot = 1'b1; m_state = 0; end
        endcase
        return p;
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        since += n;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d, input string tag);
        bit ep;
        ep = model_step(a, d, since);
        wr_addr = a; wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
        since = 1;
        check(wr_ok == ep, {tag, " wr_ok"}, int'(wr_ok), int'(ep));
        check(prot_on == m_prot, {tag, " prot_on"}, int'(prot_on), int'(m_prot));
    endtask

    task automatic prefix(input logic [7:0] key, input string tag);
        wr(15'h5555, 8'hAA, tag);
        wr(15'h2AAA, 8'h55, tag);
        wr(15'h5555, key, tag);
    endtask

    initial begin
        #100000000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check(wr_ok == 1'b0, "R1 reset wr_ok", int'(wr_ok), 0);
        check(prot_on == 1'b0, "R1 reset prot_on", int'(prot_on), 0);
        rst_n = 1'b1; por_n = 1'b1;
        idle(2);

        wr(15'h1234, 8'h5A, "R2 plain write");
        idle(1);
        check(wr_ok == 1'b0, "R2 no strobe", int'(wr_ok), 0);
        prefix(8'hA0, "R3 prefix cycles");
        idle(3);
        wr(15'h0042, 8'h11, "R4 arm data write");
        check(prot_on == 1'b1, "R4 flag set", int'(prot_on), 1);
        wr(15'h0042, 8'h22, "R6 unguarded write");
        prefix(8'hA0, "R7 prefix");
        wr(15'h5555, 8'hAA, "R7 data equal to code");
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; m_state = 0;
        check(prot_on == 1'b1, "R11 flag held", int'(prot_on), 1);
        wr(15'h5555, 8'hAA, "R8 start");
        wr(15'h0100, 8'h55, "R8 break");
        wr(15'h2AAA, 8'h55, "R8 judged idle");
        wr(15'h5555, 8'hAA, "R9 start");
        idle(W - 1);
        wr(15'h2AAA, 8'h55, "R9 gap at limit");
        idle(W);
        wr(15'h5555, 8'hA0, "R9 gap over limit");
        prefix(DK, "R10 disable");
        check(prot_on == 1'b0, "R10 flag cleared", int'(prot_on), 0);
        prefix(8'hA0, "R5 bare prefix");
        idle(W + 2);
        check(prot_on == 1'b0, "R5 flag unchanged", int'(prot_on), 0);
        wr(15'h0007, 8'h07, "R5 after expiry");

        for (int i = 0; i < 3000; i++) begin
            int k = $urandom_range(0, 9);
            logic [14:0] a;
            logic [7:0] d;
            case (k)
                0, 1: begin a = 15'h5555; d = 8'hAA; end
                2, 3: begin a = 15'h2AAA; d = 8'h55; end
                4, 5: begin a = 15'h5555; d = 8'hA0; end
                6:    begin a = 15'h5555; d = DK; end
                default: begin a = 15'($urandom); d = 8'($urandom); end
            endcase
            if ($urandom_range(0, 7) == 0) idle($urandom_range(W - 2, W + 2) - 1);
            wr(a, d, "R2-mix random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule